// File: doc/BRIEF.md
# Prioritized External Interrupt Controller

This block gathers six active-low external interrupt request pins and turns them into one request to a processor core, with a one-hot grant and an encoded index for the winning line. Three of the pins can each be set to level or falling-edge sensitivity. Two pins are always level-sensitive and one is always edge-sensitive. Edge requests are held in a per-line pending latch until the core acknowledges that line. A per-line mask decides which pending requests may win. A fixed priority order picks one winner among the unmasked ones.

Two of the configurable pins share package pins with a serial port. A system-control input selects their function, and they count as interrupts only when it selects interrupt mode. Every pin passes through a synchronizer before it is used. This adds a fixed recognition delay. The core answers a grant with a one-cycle acknowledge that carries the serviced index.

Line indices used throughout: 0 = configurable line A (port-shared), 1 = configurable line B (port-shared), 2 = fixed level line C, 3 = fixed level line D, 4 = fixed edge line E, 5 = configurable line F.

Top module: `ext_irq_ctrl`

## Requirements
- R1: While reset is held, and right after it, `irq_o` is 0, `grant_o` is 0 and no edge latch is pending.
- R2: With two synchronizer stages, a level request driven low before a clock edge appears on the outputs after the second following edge. A falling edge appears after the third following edge.
- R3: In level mode (a `sense_edge_i` bit of 0, or lines 2 and 3), a line is pending only while its synchronized value is low, and nothing is latched.
- R4: In edge mode, a high-to-low transition of the synchronized line sets that line's latch. Holding the line at either level afterwards creates no new request.
- R5: An acknowledge (`ack_valid_i` = 1) clears only the latch of line `ack_idx_i`. A falling edge detected on that line in the acknowledge cycle leaves the latch set.
- R6: A line whose `mask_i` bit is 0 is never granted. A masked edge latch stays pending and is granted once it is unmasked.
- R7: Among the unmasked pending lines, the highest index wins. `grant_o` is one-hot at that bit and `grant_idx_o` holds its index. Both are 0 when nothing is eligible.
- R8: When `port_irq_mode_i` is 0, lines 0 and 1 are never pending and their latches are cleared.
- R9: Lines 2 and 3 are always level-sensitive and line 4 is always edge-sensitive, whatever `sense_edge_i` holds. `sense_edge_i` bits 0, 1 and 2 set lines 0, 1 and 5.
- R10: `irq_o` is 1 exactly when `grant_o` has a bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n_i | input | 6 | Active-low request pins, index as listed above |
| sense_edge_i | input | 3 | Edge(1)/level(0) select for lines 0, 1, 5 |
| mask_i | input | 6 | Per-line enable, 1 = may be granted |
| port_irq_mode_i | input | 1 | 1 = shared pins act as interrupt lines 0 and 1 |
| ack_valid_i | input | 1 | One-cycle service acknowledge |
| ack_idx_i | input | 3 | Index of the serviced line |
| irq_o | output | 1 | Request to the core |
| grant_o | output | 6 | One-hot winning line |
| grant_idx_o | output | 3 | Encoded winning line |

## Verification
The hardest case to reach is an acknowledge that lands in the same cycle as a new falling edge on the same line. The edge must have passed the synchronizer and the previous-sample stage just as the acknowledge arrives. A directed sequence gets there in steps. It first latches one edge. It then releases the pin long enough for both stages to read high, drives it low again, and waits exactly two edges before pulsing the acknowledge. Random stimulus with rare pin flips, mask and mode changes, and stray acknowledges then checks against a cycle model kept in the bench.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] req_n_i,
  input  logic [2:0] sense_edge_i,
  input  logic [5:0] mask_i,
  input  logic       port_irq_mode_i,
  input  logic       ack_valid_i,
  input  logic [2:0] ack_idx_i,
  output logic       irq_o,
  output logic [5:0] grant_o,
  output logic [2:0] grant_idx_o
);
  localparam int N = 6;

  logic [SYNC_STAGES-1:0][N-1:0] sync_q;
  logic [N-1:0] prev_q, lat_q;
  logic [N-1:0] s, fall, em, en, ackhit, pend, elig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= '1;
      lat_q  <= '0;
    end else begin
      sync_q[0] <= req_n_i;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      prev_q <= s;
      lat_q  <= em & en & ((lat_q & ~ackhit) | fall);
    end
  end

  assign s      = sync_q[SYNC_STAGES-1];
  assign fall   = prev_q & ~s;
  assign em     = {sense_edge_i[2], 1'b1, 2'b00, sense_edge_i[1:0]};
  assign en     = {4'b1111, {2{port_irq_mode_i}}};
  assign ackhit = ack_valid_i ? (N'(1) << ack_idx_i) : '0;
  assign pend   = en & ((em & lat_q) | (~em & ~s));
  assign elig   = pend & mask_i;
  assign irq_o  = |elig;

  always_comb begin
    grant_idx_o = '0;
    for (int i = 0; i < N; i++)
      if (elig[i]) grant_idx_o = 3'(i);
    grant_o = irq_o ? (N'(1) << grant_idx_o) : '0;
  end

  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_o));
  a_r10_irq_matches: assert property (@(posedge clk) disable iff (!rst_n) irq_o == (grant_o != '0));
  a_r6_masked_not_granted: assert property (@(posedge clk) disable iff (!rst_n) (grant_o & ~mask_i) == '0);
  a_r8_port_off: assert property (@(posedge clk) disable iff (!rst_n) !port_irq_mode_i |-> grant_o[1:0] == 2'b00);

  for (genvar g = 0; g < N; g++) begin : g_chk
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid_i && ack_idx_i == 3'(g) && !fall[g]) |=> !lat_q[g]);
    a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q[g] && em[g] && en[g] && !ackhit[g]) |=> lat_q[g]);
    a_r3_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      !em[g] |=> !lat_q[g]);
  end
endmodule

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [5:0] req_n = '1, mask = '1;
  logic [2:0] sense = '0, ack_idx = '0;
  logic port = 1, ack_v = 0;
  logic irq;
  logic [5:0] grant;
  logic [2:0] gidx;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .req_n_i(req_n), .sense_edge_i(sense),
    .mask_i(mask), .port_irq_mode_i(port), .ack_valid_i(ack_v), .ack_idx_i(ack_idx),
    .irq_o(irq), .grant_o(grant), .grant_idx_o(gidx));

  // reference model built from the requirements
  logic [5:0] m1, m2, m3, mlat;
  function automatic logic [5:0] edge_sel(input logic [2:0] se);
    return {se[2], 1'b1, 2'b00, se[1:0]};
  endfunction
  function automatic logic [5:0] live(input logic p);
    return {4'b1111, p, p};
  endfunction
  function automatic logic [5:0] exp_grant();
    logic [5:0] e, pnd;
    e = edge_sel(sense);
    pnd = live(port) & ((e & mlat) | (~e & ~m2)) & mask;
    for (int i = 5; i >= 0; i--) if (pnd[i]) return 6'(1) << i;
    return '0;
  endfunction
  function automatic logic [2:0] enc(input logic [5:0] g);
    for (int i = 0; i < 6; i++) if (g[i]) return 3'(i);
    return '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= '1; m2 <= '1; m3 <= '1; mlat <= '0;
    end else begin
      logic [5:0] a;
      a = ack_v ? (6'(1) << ack_idx) : '0;
      m1 <= req_n; m2 <= m1; m3 <= m2;
      mlat <= edge_sel(sense) & live(port) & ((mlat & ~a) | (m3 & ~m2));
    end
  end

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask
  task automatic model_chk();
    chk("R7 grant", grant, exp_grant());
    chk("R7 index", 6'(gidx), 6'(enc(exp_grant())));
    chk("R10 irq", 6'(irq), 6'(exp_grant() != 0));
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset irq", 6'(irq), 0); chk("R1 reset grant", grant, 0);
    rst_n = 1; step(1);
    chk("R1 after reset", grant, 0);
    // R2/R3 level on line 5
    req_n[5] = 0; step(1);
    chk("R2 level not yet", grant, 0);
    step(1); chk("R2 level seen", grant, 6'b100000); chk("R7 idx5", 6'(gidx), 5);
    req_n[5] = 1; step(1); chk("R3 still low in sync", grant, 6'b100000);
    step(1); chk("R3 level released no latch", grant, 0);
    // R4 edge on line 4
    req_n[4] = 0; step(2); chk("R2 edge not yet", grant, 0);
    step(1); chk("R4 edge latched", grant, 6'b010000);
    step(5); chk("R4 held", grant, 6'b010000);
    ack_v = 1; ack_idx = 4; step(1); ack_v = 0;
    chk("R5 ack clears", grant, 0);
    step(3); chk("R4 low hold no new request", grant, 0);
    req_n[4] = 1; step(3);
    // R5 edge in ack cycle
    req_n[4] = 0; step(3); chk("R5 setup latched", grant, 6'b010000);
    req_n[4] = 1; step(3);
    req_n[4] = 0; step(2);
    ack_v = 1; ack_idx = 4; step(1); ack_v = 0;
    chk("R5 edge with ack kept", grant, 6'b010000);
    ack_v = 1; step(1); ack_v = 0;
    chk("R5 second ack clears", grant, 0);
    // R5 only matching line: latch line 4 and line 5 (edge)
    req_n[4] = 1; sense = 3'b100; step(3);
    req_n[4] = 0; req_n[5] = 0; step(3);
    chk("R7 both latched, 5 wins", grant, 6'b100000);
    ack_v = 1; ack_idx = 5; step(1); ack_v = 0;
    chk("R5 only line5 cleared", grant, 6'b010000);
    ack_v = 1; ack_idx = 4; step(1); ack_v = 0;
    req_n[4] = 1; req_n[5] = 1; sense = 0; step(3);
    // R6 masked edge stays pending
    mask[4] = 0; req_n[4] = 0; step(4);
    chk("R6 masked not granted", grant, 0);
    mask[4] = 1; step(1); chk("R6 unmasked granted", grant, 6'b010000);
    ack_v = 1; ack_idx = 4; step(1); ack_v = 0; req_n[4] = 1; step(3);
    // R8 port mode
    port = 0; req_n[0] = 0; step(3); chk("R8 port off", grant, 0);
    port = 1; step(1); chk("R8 port on", grant, 6'b000001);
    req_n[1] = 0; step(2); chk("R7 line1 over line0", grant, 6'b000010);
    req_n[0] = 1; req_n[1] = 1; step(3);
    // R9 fixed sensitivities
    sense = 3'b111; req_n[2] = 0; step(2); chk("R9 line2 level", grant, 6'b000100);
    req_n[2] = 1; step(2); chk("R9 line2 no latch", grant, 0);
    sense = 0; step(2);
    // random phase
    void'($urandom(32'd1234));
    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < 6; b++) if ($urandom_range(0, 9) == 0) req_n[b] = ~req_n[b];
      if ($urandom_range(0, 15) == 0) mask = 6'($urandom);
      if ($urandom_range(0, 31) == 0) sense = 3'($urandom);
      if ($urandom_range(0, 63) == 0) port = ~port;
      ack_v = ($urandom_range(0, 3) == 0);
      ack_idx = ($urandom_range(0, 1) == 0 && grant != 0) ? gidx : 3'($urandom_range(0, 5));
      #1; model_chk();
      step(1);
    end
    ack_v = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule